// File: doc/BRIEF.md
# Burst Address Counter Register

This block generates the internal address for one port of a synchronous memory. At every rising clock edge it chooses one of four actions: force the address to zero, take a new address from the external bus, step the stored address up by one, or keep the stored address. The address it chooses is registered on that edge and drives `addr_out` for the cycle that follows. The memory access of that cycle uses this address.

The stored value is always the last address that was used. A later step is therefore taken from a loaded or cleared address as well as from a stepped one. The three controls are active low and have a fixed priority: clear first, then load, then advance. Nothing else, such as a chip enable, gates them. A separate synchronous system reset puts the register at zero. Two incrementer structures can be chosen by parameter: an adder that synthesis infers, or an explicit chain that toggles each bit when all lower bits are one.

Top module: `burst_addr_ctr`

## Requirements
- R1: If `clr_n` is 0 at a rising edge, `addr_out` is 0 after that edge. `strobe_n`, `adv_n` and `ext_addr` are ignored in that cycle.
- R2: If `clr_n` is 1 and `strobe_n` is 0 at a rising edge, `addr_out` after that edge equals `ext_addr` as sampled at that edge. `adv_n` is ignored.
- R3: If `clr_n` and `strobe_n` are 1 and `adv_n` is 0 at a rising edge, `addr_out` after that edge is its previous value plus one.
- R4: If `clr_n`, `strobe_n` and `adv_n` are all 1 at a rising edge, `addr_out` keeps its value, whatever is on `ext_addr`.
- R5: Advancing from the all-ones address gives address 0.
- R6: If `rst_n` is 0 at a rising edge, `addr_out` is 0 after that edge. This holds whatever the other controls are.
- R7: An advance counts from whatever address was last used, including one just loaded or cleared. Clear, load and advance may follow one another in back-to-back cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| ext_addr | input | AW | External address bus |
| strobe_n | input | 1 | Load `ext_addr`, active low |
| adv_n | input | 1 | Advance stored address, active low |
| clr_n | input | 1 | Clear address to zero, active low |
| addr_out | output | AW | Internal address for the current cycle |

## Verification
The assertions take for granted that every control input is a known 0 or 1 at each sampled edge. They also assume that `rst_n` is held low over the first edges, so the register has a defined value before any step or hold is checked against its past. The stimulus drives all inputs on the falling edge, starts with several reset cycles, and never leaves a control undriven. The vectors cover every combination of the three controls that matters for priority, and every one of them settles to a known address.

// File: rtl/bac_pkg.sv
package bac_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_ADV   = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } bac_op_e;

   localparam int unsigned INC_ADDER = 0;
   localparam int unsigned INC_CHAIN = 1;

endpackage

// File: rtl/bac_ctl_decode.sv
module bac_ctl_decode
   import bac_pkg::*;
(
   input  logic    clr_n,
   input  logic    strobe_n,
   input  logic    adv_n,
   output bac_op_e op
);

   // Fixed priority: clear, then load, then advance (R1, R2, R3)
   always_comb begin
      if (!clr_n)
         op = OP_CLEAR;
      else if (!strobe_n)
         op = OP_LOAD;
      else if (!adv_n)
         op = OP_ADV;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/bac_incr.sv
module bac_incr #(
   parameter int unsigned AW   = 16,
   parameter int unsigned IMPL = 1
) (
   input  logic [AW-1:0] a,
   output logic [AW-1:0] y
);

   localparam int unsigned CW = AW + 1;

   generate
      if (IMPL > 1) begin : g_bad_impl
         $error("bac_incr: IMPL must be 0 or 1");
      end

      if (IMPL == 0) begin : g_adder
         assign y = a + {{(AW-1){1'b0}}, 1'b1};
      end else begin : g_chain
         // ones_below[i] is high when every bit below i is one
         logic [CW-1:0] ones_below;
         assign ones_below[0] = 1'b1;
         for (genvar i = 0; i < AW; i++) begin : g_bit
            assign ones_below[i+1] = ones_below[i] & a[i];
            assign y[i]            = a[i] ^ ones_below[i];
         end
      end
   endgenerate

endmodule

// File: rtl/bac_next_sel.sv
module bac_next_sel
   import bac_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  bac_op_e       op,
   input  logic [AW-1:0] ext,
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] inc,
   output logic [AW-1:0] nxt
);

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = ext;
         OP_ADV:   nxt = inc;
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
   import bac_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned INC_IMPL = INC_CHAIN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic          strobe_n,
   input  logic          adv_n,
   input  logic          clr_n,
   output logic [AW-1:0] addr_out
);

   localparam logic [AW-1:0] ADDR_ZERO = '0;
   localparam logic [AW-1:0] ADDR_TOP  = '1;

   generate
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("burst_addr_ctr: AW must be within 1..64");
      end
   endgenerate

   bac_op_e       op;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_inc;
   logic [AW-1:0] addr_nxt;

   bac_ctl_decode u_dec (
      .clr_n    (clr_n),
      .strobe_n (strobe_n),
      .adv_n    (adv_n),
      .op       (op)
   );

   bac_incr #(.AW(AW), .IMPL(INC_IMPL)) u_inc (
      .a (addr_q),
      .y (addr_inc)
   );

   bac_next_sel #(.AW(AW)) u_sel (
      .op  (op),
      .ext (ext_addr),
      .cur (addr_q),
      .inc (addr_inc),
      .nxt (addr_nxt)
   );

   // The register holds the address in use, so a later step counts from it (R7)
   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= ADDR_ZERO;
      else
         addr_q <= addr_nxt;
   end

   assign addr_out = addr_q;

   a_r1_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> addr_out == ADDR_ZERO);

   a_r2_load_external: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !strobe_n) |=> addr_out == $past(ext_addr));

   a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && clr_n && strobe_n && !adv_n)
         |=> addr_out == AW'($past(addr_out) + 1'b1));

   a_r4_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && clr_n && strobe_n && adv_n) |=> $stable(addr_out));

   a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && clr_n && strobe_n && !adv_n && addr_out == ADDR_TOP)
         |=> addr_out == ADDR_ZERO);

   a_r6_sys_reset: assert property (@(posedge clk)
      !rst_n |=> addr_out == ADDR_ZERO);

endmodule

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

   localparam int AW   = 16;
   localparam int NVEC = 15;

   // {clr_n, strobe_n, adv_n, ext_addr, expected addr_out}
   localparam logic [34:0] VEC [NVEC] = '{
      {3'b110, 16'h0000, 16'h0001},  // R3 step from reset value
      {3'b110, 16'h9999, 16'h0002},  // R3 ext ignored
      {3'b111, 16'h7777, 16'h0002},  // R4 hold, ext changing
      {3'b101, 16'h1234, 16'h1234},  // R2 load
      {3'b110, 16'h0000, 16'h1235},  // R7 step after load
      {3'b100, 16'h00F0, 16'h00F0},  // R2 load beats advance
      {3'b000, 16'hABCD, 16'h0000},  // R1 clear beats load and advance
      {3'b110, 16'h0000, 16'h0001},  // R7 step after clear
      {3'b101, 16'hFFFF, 16'hFFFF},  // R2 load all ones
      {3'b110, 16'h0000, 16'h0000},  // R5 wrap
      {3'b111, 16'h5555, 16'h0000},  // R4 hold at zero
      {3'b101, 16'h7FFF, 16'h7FFF},  // R2 load
      {3'b110, 16'h0000, 16'h8000},  // R3 carry through all low bits
      {3'b011, 16'h3333, 16'h0000},  // R1 clear alone
      {3'b100, 16'h0042, 16'h0042}   // R7 load right after clear
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 1, 12:       return "R3";
         2, 10:          return "R4";
         3, 5, 8, 11:    return "R2";
         4, 7, 14:       return "R7";
         6, 13:          return "R1";
         default:        return "R5";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          strobe_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [AW-1:0] addr_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   burst_addr_ctr #(.AW(AW)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_addr (ext_addr),
      .strobe_n (strobe_n),
      .adv_n    (adv_n),
      .clr_n    (clr_n),
      .addr_out (addr_out)
   );

   task automatic check(string tag, logic [AW-1:0] exp);
      n_tests++;
      if (addr_out !== exp) begin
         n_fail++;
         $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
      end
   endtask

   // Drive on the falling edge, let one rising edge act, sample at the next falling edge
   task automatic step(logic c, logic s, logic a, logic [AW-1:0] e);
      clr_n    = c;
      strobe_n = s;
      adv_n    = a;
      ext_addr = e;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R6 reset state", 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16]);
         check(vec_tag(i), VEC[i][15:0]);
      end

      // R6: system reset wins over a load request
      step(1'b1, 1'b0, 1'b1, 16'h4444);
      check("R2 load before reset", 16'h4444);
      rst_n = 1'b0;
      step(1'b1, 1'b0, 1'b0, 16'h5A5A);
      check("R6 reset overrides load", 16'h0000);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0, 16'h0000);
      check("R6 step after reset", 16'h0001);

      // R7: clear, advance, advance back to back
      step(1'b0, 1'b1, 1'b1, 16'h0000);
      check("R7 clear", 16'h0000);
      step(1'b1, 1'b1, 1'b0, 16'h0000);
      check("R7 first step", 16'h0001);
      step(1'b1, 1'b1, 1'b0, 16'h0000);
      check("R7 second step", 16'h0002);

      // R5: load near the top and run through the wrap
      step(1'b1, 1'b0, 1'b1, 16'hFFFE);
      step(1'b1, 1'b1, 1'b0, 16'h0000);
      check("R5 below top", 16'hFFFF);
      step(1'b1, 1'b1, 1'b0, 16'h0000);
      check("R5 wrap", 16'h0000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule